// File: doc/BRIEF.md
# Processor Stop-Clock Power-State Controller

This block tracks the low-power state of a processor core. It is a synchronous state machine with six states: Run (1), Auto-Halt (2), Stop-Grant (3), Halt/Grant-Snoop (4), Sleep (5) and Deep-Sleep (6). A halt request, an active-low stop-clock request, an active-low sleep request and a bus-clock-alive indication drive it down through these tiers. Wake events and snoop traffic bring it back up. For each state it reports whether snoops and interrupts may be accepted, and whether the core's internal clock runs.

The snoop state remembers whether it was entered from Auto-Halt or from Stop-Grant, and it returns there when the snoop completes. Stop-Grant remembers whether it was entered from Auto-Halt, and uses that to choose its exit state. A configuration bit chooses whether the internal clock really stops in the three deepest states. The stop, sleep, bus-clock and wake inputs are asynchronous and pass through a synchronizer chain. The halt, snoop-request and snoop-done inputs are already in the core's clock domain.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While rst_n is sampled low at a rising edge, the state goes to Run (code 1) from any state, including Sleep and Deep-Sleep. Run reports snoop_ok=1, intr_ok=1 and core_clk_en=1.
- R2: In Run, a one-cycle halt_req moves the state to Auto-Halt (code 2) at the same edge.
- R3: In Auto-Halt, a synchronized high on any of wake_init, wake_businit, wake_intr or wake_smi returns the state to Run. A wake has priority over stop-clock in that state.
- R4: A synchronized low on stop_req_n moves Run or Auto-Halt to Stop-Grant (code 3). In Run, stop-clock has priority over halt_req.
- R5: When stop_req_n is synchronized high in Stop-Grant, the state goes to Auto-Halt if Stop-Grant was entered from Auto-Halt, and to Run otherwise.
- R6: snoop_req in Auto-Halt or Stop-Grant moves the state to Halt/Grant-Snoop (code 4). snoop_done there returns the state to the state it came from.
- R7: A synchronized low on sleep_req_n in Stop-Grant enters Sleep (code 5). A synchronized high on sleep_req_n in Sleep returns to Stop-Grant.
- R8: In Sleep, a synchronized low on bclk_alive enters Deep-Sleep (code 6). A synchronized high on bclk_alive in Deep-Sleep returns to Sleep.
- R9: snoop_ok is 1 in states 1 to 4 and 0 in states 5 and 6. intr_ok is 1 in states 1 to 3 and 0 in states 4 to 6.
- R10: core_clk_en is 0 in states 3, 5 and 6 when clk_stop_en is 1, and 1 in every other case.
- R11: An asynchronous input that changes before rising edge k first alters the state at edge k+2, because of the two synchronizer stages.
- R12: Inputs are ignored outside the states where they apply: sleep_req_n outside Stop-Grant and Sleep, bclk_alive outside Sleep and Deep-Sleep, halt_req outside Run, and snoop_req outside Auto-Halt and Stop-Grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | One-cycle halt request pulse (synchronous) |
| stop_req_n | input | 1 | Active-low stop-clock request (asynchronous) |
| sleep_req_n | input | 1 | Active-low sleep request (asynchronous) |
| bclk_alive | input | 1 | High while the external bus clock runs (asynchronous) |
| snoop_req | input | 1 | Snoop event request (synchronous) |
| snoop_done | input | 1 | Snoop serviced handshake (synchronous) |
| wake_init | input | 1 | Init wake event (asynchronous) |
| wake_businit | input | 1 | Bus-init wake event (asynchronous) |
| wake_intr | input | 1 | Interrupt wake event (asynchronous) |
| wake_smi | input | 1 | System-management interrupt wake event (asynchronous) |
| clk_stop_en | input | 1 | Configuration: 1 lets the internal clock stop in deep states |
| state_code | output | 3 | Current state, encoded 1 to 6 |
| snoop_ok | output | 1 | Snoops may be accepted |
| intr_ok | output | 1 | Interrupts may be accepted |
| core_clk_en | output | 1 | Internal clock-gate enable |

## Verification
Any wrong internal state shows up on state_code in the same cycle, because that output is the state register itself. A bad remembered origin stays hidden until the matching exit. A wrong snoop-return choice appears on the cycle after snoop_done. A wrong Stop-Grant origin appears two edges after stop_req_n is released. The reference model runs beside the design and compares every output on every clock, so a divergence is reported within one cycle of the edge where it starts.

// File: rtl/pwr_state_pkg.sv
// Package: shared state encoding for the stop-clock power-state controller.
// Assumes: codes 1..6 are visible at the block's ports; 0 and 7 are unused.
package pwr_state_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        PS_RUN   = 3'd1,
        PS_HALT  = 3'd2,
        PS_GRANT = 3'd3,
        PS_SNOOP = 3'd4,
        PS_SLEEP = 3'd5,
        PS_DEEP  = 3'd6
    } pstate_t;
endpackage

// File: rtl/sync_bank.sv
// Module: sync_bank
// A bank of flop-chain synchronizers, one chain per bit of d.
// Assumes: each bit is an independent level signal. Reset loads RESET_VAL
// into every stage, so the chain reads as the idle level after reset.
module sync_bank #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first stage samples the raw asynchronous inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RESET_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // later stages shift the sampled value along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RESET_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_fsm.sv
// Module: pwr_fsm
// The power-state transition logic. It remembers where Stop-Grant and the
// snoop state were entered from, and uses that to choose their exits.
// Assumes: the stop, sleep, bclk and wake inputs are already synchronized;
// halt_req, snoop_req and snoop_done are in this clock domain.
module pwr_fsm
    import pwr_state_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt_req,
    input  logic    stop_n_s,
    input  logic    sleep_n_s,
    input  logic    bclk_s,
    input  logic    wake_s,
    input  logic    snoop_req,
    input  logic    snoop_done,
    output pstate_t state
);
    pstate_t state_nx;
    pstate_t snoop_ret, snoop_ret_nx;
    logic    grant_from_halt, grant_from_halt_nx;
    logic    past_ok;

    // choose the next state and the remembered origin fields
    always_comb begin
        state_nx           = state;
        snoop_ret_nx       = snoop_ret;
        grant_from_halt_nx = grant_from_halt;
        unique case (state)
            PS_RUN: begin
                if (!stop_n_s) begin
                    state_nx           = PS_GRANT;
                    grant_from_halt_nx = 1'b0;
                end else if (halt_req) begin
                    state_nx = PS_HALT;
                end
            end
            PS_HALT: begin
                if (wake_s) begin
                    state_nx = PS_RUN;
                end else if (!stop_n_s) begin
                    state_nx           = PS_GRANT;
                    grant_from_halt_nx = 1'b1;
                end else if (snoop_req) begin
                    state_nx     = PS_SNOOP;
                    snoop_ret_nx = PS_HALT;
                end
            end
            PS_GRANT: begin
                if (stop_n_s) begin
                    state_nx = grant_from_halt ? PS_HALT : PS_RUN;
                end else if (!sleep_n_s) begin
                    state_nx = PS_SLEEP;
                end else if (snoop_req) begin
                    state_nx     = PS_SNOOP;
                    snoop_ret_nx = PS_GRANT;
                end
            end
            PS_SNOOP: begin
                if (snoop_done) state_nx = snoop_ret;
            end
            PS_SLEEP: begin
                if (sleep_n_s)    state_nx = PS_GRANT;
                else if (!bclk_s) state_nx = PS_DEEP;
            end
            PS_DEEP: begin
                if (bclk_s) state_nx = PS_SLEEP;
            end
            default: state_nx = PS_RUN;
        endcase
    end

    // register the state and origin memory; reset has the highest priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= PS_RUN;
            snoop_ret       <= PS_HALT;
            grant_from_halt <= 1'b0;
        end else begin
            state           <= state_nx;
            snoop_ret       <= snoop_ret_nx;
            grant_from_halt <= grant_from_halt_nx;
        end
    end

    // mark cycles where $past refers to a cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6
    snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state) == PS_SNOOP && state != PS_SNOOP)
            |-> (state == $past(snoop_ret)));

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state == PS_SLEEP)
            |-> ($past(state) == PS_GRANT || $past(state) == PS_SLEEP
                 || $past(state) == PS_DEEP));

    // R8
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state == PS_DEEP)
            |-> ($past(state) == PS_SLEEP || $past(state) == PS_DEEP));

    // R5
    grant_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state) == PS_GRANT && state == PS_HALT)
            |-> $past(grant_from_halt));

    // R2
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state) == PS_RUN && state == PS_HALT)
            |-> $past(halt_req));
endmodule

// File: rtl/pwr_out_dec.sv
// Module: pwr_out_dec
// Decodes the permission flags and the clock-gate enable from the state.
// Assumes: clk_stop_en is a quasi-static configuration level.
module pwr_out_dec
    import pwr_state_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_t state,
    input  logic    clk_stop_en,
    output logic    snoop_ok,
    output logic    intr_ok,
    output logic    clk_en
);
    logic deep_tier;

    // per-state permissions and clock-stop eligibility
    always_comb begin
        snoop_ok  = 1'b0;
        intr_ok   = 1'b0;
        deep_tier = 1'b0;
        unique case (state)
            PS_RUN, PS_HALT: begin
                snoop_ok = 1'b1;
                intr_ok  = 1'b1;
            end
            PS_GRANT: begin
                snoop_ok  = 1'b1;
                intr_ok   = 1'b1;
                deep_tier = 1'b1;
            end
            PS_SNOOP: snoop_ok = 1'b1;
            PS_SLEEP, PS_DEEP: deep_tier = 1'b1;
            default: begin
                snoop_ok = 1'b1;
                intr_ok  = 1'b1;
            end
        endcase
    end

    assign clk_en = !(deep_tier && clk_stop_en);

    // R9
    no_snoop_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SLEEP || state == PS_DEEP) |-> (!snoop_ok && !intr_ok));

    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |-> (clk_stop_en && state != PS_RUN && state != PS_HALT
                       && state != PS_SNOOP));
endmodule

// File: rtl/pwr_state_ctrl.sv
// Module: pwr_state_ctrl (top)
// Stop-clock power-state controller: it synchronizes the asynchronous
// controls, runs the state machine and decodes the per-state outputs.
// Assumes: a synchronous active-low reset held for at least SYNC_STAGES cycles.
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic               stop_req_n,
    input  logic               sleep_req_n,
    input  logic               bclk_alive,
    input  logic               snoop_req,
    input  logic               snoop_done,
    input  logic               wake_init,
    input  logic               wake_businit,
    input  logic               wake_intr,
    input  logic               wake_smi,
    input  logic               clk_stop_en,
    output logic [STATE_W-1:0] state_code,
    output logic               snoop_ok,
    output logic               intr_ok,
    output logic               core_clk_en
);
    localparam int ASYNC_N = 7;
    localparam logic [ASYNC_N-1:0] ASYNC_IDLE = 7'b111_0000;

    logic [ASYNC_N-1:0] async_raw, async_s;
    pstate_t            state;

    assign async_raw = {stop_req_n, sleep_req_n, bclk_alive,
                        wake_init, wake_businit, wake_intr, wake_smi};

    sync_bank #(
        .WIDTH    (ASYNC_N),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(ASYNC_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (async_raw),
        .q    (async_s)
    );

    pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_req  (halt_req),
        .stop_n_s  (async_s[6]),
        .sleep_n_s (async_s[5]),
        .bclk_s    (async_s[4]),
        .wake_s    (|async_s[3:0]),
        .snoop_req (snoop_req),
        .snoop_done(snoop_done),
        .state     (state)
    );

    pwr_out_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .clk_stop_en(clk_stop_en),
        .snoop_ok   (snoop_ok),
        .intr_ok    (intr_ok),
        .clk_en     (core_clk_en)
    );

    assign state_code = state;
endmodule

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, stop_req_n = 1, sleep_req_n = 1, bclk_alive = 1;
    logic snoop_req = 0, snoop_done = 0;
    logic wake_init = 0, wake_businit = 0, wake_intr = 0, wake_smi = 0;
    logic clk_stop_en = 1;
    logic [2:0] state_code;
    logic snoop_ok, intr_ok, core_clk_en;

    int total_d = 0, bad_d = 0, total_m = 0, bad_m = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwr_state_ctrl uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req_n(stop_req_n),
        .sleep_req_n(sleep_req_n), .bclk_alive(bclk_alive), .snoop_req(snoop_req),
        .snoop_done(snoop_done), .wake_init(wake_init), .wake_businit(wake_businit),
        .wake_intr(wake_intr), .wake_smi(wake_smi), .clk_stop_en(clk_stop_en),
        .state_code(state_code), .snoop_ok(snoop_ok), .intr_ok(intr_ok),
        .core_clk_en(core_clk_en)
    );

    // reference model: async samples delayed by two edges through a queue
    int m_st = 1;
    int m_from_halt = 0;
    int m_ret = 2;
    logic [3:0] hist [$];   // {stop_n, sleep_n, bclk, any_wake}

    always @(posedge clk) begin
        logic [3:0] s;
        int nx;
        if (!rst_n) begin
            m_st = 1; m_from_halt = 0; m_ret = 2;
            hist.delete(); hist.push_back(4'b1110); hist.push_back(4'b1110);
        end else begin
            s = hist.pop_front();
            nx = m_st;
            if (m_st == 1) begin
                if (!s[3]) begin nx = 3; m_from_halt = 0; end
                else if (halt_req) nx = 2;
            end else if (m_st == 2) begin
                if (s[0]) nx = 1;
                else if (!s[3]) begin nx = 3; m_from_halt = 1; end
                else if (snoop_req) begin nx = 4; m_ret = 2; end
            end else if (m_st == 3) begin
                if (s[3]) nx = (m_from_halt != 0) ? 2 : 1;
                else if (!s[2]) nx = 5;
                else if (snoop_req) begin nx = 4; m_ret = 3; end
            end else if (m_st == 4) begin
                if (snoop_done) nx = m_ret;
            end else if (m_st == 5) begin
                if (s[2]) nx = 3;
                else if (!s[1]) nx = 6;
            end else if (m_st == 6) begin
                if (s[1]) nx = 5;
            end
            m_st = nx;
            hist.push_back({stop_req_n, sleep_req_n, bclk_alive,
                            wake_init | wake_businit | wake_intr | wake_smi});
        end
    end

    // compare every output against the model on every clock (R9 R10 via flags)
    always @(negedge clk) begin
        int e_sn, e_in, e_ce;
        if (rst_n && !finished) begin
            e_sn = (m_st <= 4) ? 1 : 0;
            e_in = (m_st <= 3) ? 1 : 0;
            e_ce = (clk_stop_en && (m_st == 3 || m_st == 5 || m_st == 6)) ? 0 : 1;
            total_m++;
            if (int'(state_code) != m_st || int'(snoop_ok) != e_sn ||
                int'(intr_ok) != e_in || int'(core_clk_en) != e_ce) begin
                bad_m++;
                $display("FAIL model R9/R10 state=%0d/%0d snoop=%0d/%0d intr=%0d/%0d clk_en=%0d/%0d",
                         state_code, m_st, snoop_ok, e_sn, intr_ok, e_in, core_clk_en, e_ce);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(int exp, string tag);
        total_d++;
        if (int'(state_code) != exp) begin
            bad_d++;
            $display("FAIL %s state actual=%0d expected=%0d", tag, state_code, exp);
        end
    endtask

    task automatic chk_bit(logic act, logic exp, string tag);
        total_d++;
        if (act !== exp) begin
            bad_d++;
            $display("FAIL %s flag actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_halt();
        halt_req = 1; cyc(1); halt_req = 0;
    endtask

    task automatic pulse_snoop();
        snoop_req = 1; cyc(1); snoop_req = 0;
    endtask

    task automatic pulse_done();
        snoop_done = 1; cyc(1); snoop_done = 0;
    endtask

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(1);
        chk(1, "R1");
        chk_bit(snoop_ok, 1, "R1"); chk_bit(intr_ok, 1, "R1"); chk_bit(core_clk_en, 1, "R1");

        pulse_halt(); chk(2, "R2");
        wake_intr = 1; cyc(1); wake_intr = 0; cyc(3); chk(1, "R3");

        // R11: stop-clock seen on the third edge after the change
        stop_req_n = 0; cyc(2); chk(1, "R11"); cyc(1); chk(3, "R11");
        chk_bit(core_clk_en, 0, "R10");
        stop_req_n = 1; cyc(3); chk(1, "R5");

        pulse_halt(); chk(2, "R2");
        stop_req_n = 0; cyc(3); chk(3, "R4");
        sleep_req_n = 0; cyc(3); chk(5, "R7");
        chk_bit(intr_ok, 0, "R9"); chk_bit(snoop_ok, 0, "R9");
        bclk_alive = 0; cyc(3); chk(6, "R8");
        chk_bit(core_clk_en, 0, "R10");
        bclk_alive = 1; cyc(3); chk(5, "R8");
        sleep_req_n = 1; cyc(3); chk(3, "R7");
        pulse_snoop(); chk(4, "R6");
        chk_bit(snoop_ok, 1, "R9"); chk_bit(intr_ok, 0, "R9");
        cyc(2); chk(4, "R6");
        pulse_done(); chk(3, "R6");
        stop_req_n = 1; cyc(3); chk(2, "R5");
        pulse_snoop(); chk(4, "R6");
        pulse_done(); chk(2, "R6");
        wake_smi = 1; cyc(1); wake_smi = 0; cyc(3); chk(1, "R3");

        // R12: out-of-state inputs leave Run untouched
        sleep_req_n = 0; bclk_alive = 0; pulse_snoop(); cyc(5); chk(1, "R12");
        sleep_req_n = 1; bclk_alive = 1; cyc(3);
        // R12: halt_req ignored in Stop-Grant; bclk ignored there
        stop_req_n = 0; cyc(3); chk(3, "R4");
        bclk_alive = 0; pulse_halt(); cyc(4); chk(3, "R12");
        bclk_alive = 1; cyc(3);
        clk_stop_en = 0; cyc(1); chk_bit(core_clk_en, 1, "R10");
        clk_stop_en = 1; cyc(1); chk_bit(core_clk_en, 0, "R10");

        // wake has priority over stop in Auto-Halt
        stop_req_n = 1; cyc(3); chk(1, "R5");
        pulse_halt(); chk(2, "R2");
        stop_req_n = 0; wake_init = 1; cyc(1); wake_init = 0; cyc(2); chk(1, "R3");
        cyc(1); chk(3, "R4");

        // reset from Deep-Sleep
        sleep_req_n = 0; cyc(3); bclk_alive = 0; cyc(3); chk(6, "R8");
        rst_n = 0; cyc(1); chk(1, "R1");
        stop_req_n = 1; sleep_req_n = 1; bclk_alive = 1; cyc(2);
        rst_n = 1; cyc(4); chk(1, "R1");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total_d + total_m, bad_d + bad_m);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total_d + total_m + 1, bad_d + bad_m + 1);
            $finish;
        end
    end
endmodule